// File: doc/BRIEF.md
# Command-Addressed Sensor Register File

This block is the register file behind a byte-level serial slave in a light-sensor front end. The serial layer hands it three kinds of event: a marker that a new bus transaction has begun, a strobe with a written byte, and a strobe asking for a byte to return. The first written byte of a transaction with its top bit set is a command byte. It loads a five-bit register pointer and selects how that pointer behaves on later accesses. The pointer can hold still, advance by one after every access, or stay put while the command fires a one-cycle special-function pulse.

Behind the pointer sit the configuration registers: power and converter enable, integration-cycle count, interrupt control, two 16-bit thresholds, and gain select. They drive the rest of the sensor. The block also serves read-only identity bytes, two 16-bit conversion results captured on a conversion-done strobe, and a live manual-integration timer. Reading the low byte of a conversion result freezes its high byte, so a later high-byte read is coherent even if another conversion lands in between.

Top module: `sensreg_top`

## Requirements
- R1: After reset every writable register, both conversion results, both high-byte copies and the valid flag are 00h. The pointer is 00h in hold mode, and all three pulses are low.
- R2: A written byte with bit 7 set is a command only when it is the first byte written since the transaction marker. Its bits 6:5 select the mode: 00 hold, 01 advance, 10 hold, 11 special function. Its bits 4:0 load the pointer. Any later byte in the same transaction is data, whatever its bit 7.
- R3: In hold mode (00 or 10) and in special mode, reads and data writes leave the pointer unchanged.
- R4: In advance mode each read or data write adds one to the pointer afterwards, wrapping from 1Fh to 00h.
- R5: A special command with code 00001, 00010 or 00011 raises the interrupt-clear, manual-stop or manual-start output respectively for exactly one cycle, starting the cycle after the write. Every other code raises nothing, and no special command moves the pointer.
- R6: Register 00h stores power in bit 0 and converter enable in bit 1. It reads the valid flag in bit 4 and the interrupt input in bit 5. Valid is set by a conversion-done strobe and cleared by a data write to 00h with bit 1 clear.
- R7: Register 01h holds the integration count (8 bits). 02h holds interrupt control in bits 6:0, with bit 7 reading 0. 07h holds gain in bits 1:0, with the other bits reading 0. 03h/04h are the low/high bytes of the lower threshold and 05h/06h those of the upper threshold.
- R8: Address 12h reads 90h (part 9h in bits 7:4, revision 0h). Address 1Eh reads 80h. Writes to either are ignored.
- R9: A conversion-done strobe captures both channel inputs. 14h and 16h read the live low bytes of channel 0 and channel 1. A read of 14h (16h) copies that channel's high byte into a held copy, and 15h (17h) returns the held copy.
- R10: 18h and 19h read the low and high bytes of the timer input at the time of the read.
- R11: Writes to read-only or unmapped addresses change nothing, and unmapped addresses read 00h.
- R12: A new transaction keeps the pointer and mode. A first byte with bit 7 clear is data for the pointed register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| txn_start | input | 1 | New bus transaction begins |
| wr_en | input | 1 | Written byte strobe |
| wr_data | input | 8 | Written byte |
| rd_en | input | 1 | Read request strobe (byte consumed this cycle) |
| rd_data | output | 8 | Byte at the pointer, valid while rd_en is high |
| conv_done | input | 1 | Conversion complete, capture channel inputs |
| ch0_data | input | 16 | Channel 0 conversion result |
| ch1_data | input | 16 | Channel 1 conversion result |
| irq_active | input | 1 | Interrupt currently asserted by the interrupt logic |
| mtimer | input | 16 | Manual integration timer value |
| pwr_on | output | 1 | Power enable |
| adc_on | output | 1 | Converter enable |
| integ_time | output | 8 | Integration cycle count |
| irq_ctl | output | 7 | Interrupt control field |
| thr_low | output | 16 | Lower threshold |
| thr_high | output | 16 | Upper threshold |
| gain_sel | output | 2 | Gain select |
| irq_clr | output | 1 | One-cycle interrupt-clear pulse |
| man_stop | output | 1 | One-cycle manual-stop pulse |
| man_start | output | 1 | One-cycle manual-start pulse |

## Verification
The pointer properties assume that the serial layer never raises a read and a write strobe in the same cycle. They also assume that the transaction marker arrives in a cycle of its own before the first byte. The bench drives every event through separate single-cycle tasks, one strobe at a time, so both conditions always hold. The sweeps write all 32 addresses and read them back in advance mode. They also issue all 32 special codes, and compare each result with a register model kept inside the bench.

// File: rtl/sensreg_pkg.sv
package sensreg_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 5;
    localparam int CH_W   = 2 * BYTE_W;

    typedef enum logic [1:0] {
        XF_HOLD    = 2'b00,
        XF_ADVANCE = 2'b01,
        XF_RSVD    = 2'b10,
        XF_SPECIAL = 2'b11
    } xfer_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 5'h00;
    localparam logic [ADDR_W-1:0] A_TIME  = 5'h01;
    localparam logic [ADDR_W-1:0] A_INTC  = 5'h02;
    localparam logic [ADDR_W-1:0] A_TLO_L = 5'h03;
    localparam logic [ADDR_W-1:0] A_TLO_H = 5'h04;
    localparam logic [ADDR_W-1:0] A_THI_L = 5'h05;
    localparam logic [ADDR_W-1:0] A_THI_H = 5'h06;
    localparam logic [ADDR_W-1:0] A_GAIN  = 5'h07;
    localparam logic [ADDR_W-1:0] A_ID    = 5'h12;
    localparam logic [ADDR_W-1:0] A_D0_L  = 5'h14;
    localparam logic [ADDR_W-1:0] A_D0_H  = 5'h15;
    localparam logic [ADDR_W-1:0] A_D1_L  = 5'h16;
    localparam logic [ADDR_W-1:0] A_D1_H  = 5'h17;
    localparam logic [ADDR_W-1:0] A_TMR_L = 5'h18;
    localparam logic [ADDR_W-1:0] A_TMR_H = 5'h19;
    localparam logic [ADDR_W-1:0] A_ID2   = 5'h1E;

    localparam logic [ADDR_W-1:0] SF_CLR   = 5'h01;
    localparam logic [ADDR_W-1:0] SF_STOP  = 5'h02;
    localparam logic [ADDR_W-1:0] SF_START = 5'h03;
endpackage

// File: rtl/sensreg_cmd.sv
module sensreg_cmd
    import sensreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [ADDR_W-1:0] ptr,
    output logic [1:0]        xmode,
    output logic              reg_we,
    output logic              irq_clr,
    output logic              man_stop,
    output logic              man_start
);
    typedef struct packed {
        logic [ADDR_W-1:0] ptr;
        xfer_e             mode;
        logic              first;
        logic              clr;
        logic              stop;
        logic              start;
    } cmd_st_t;

    cmd_st_t st_d, st_q;
    logic    first_eff;
    logic    is_cmd;
    xfer_e   new_mode;

    always_comb begin
        st_d       = st_q;
        st_d.clr   = 1'b0;
        st_d.stop  = 1'b0;
        st_d.start = 1'b0;
        first_eff  = txn_start | st_q.first;
        is_cmd     = wr_en & first_eff & wr_data[BYTE_W-1];
        new_mode   = xfer_e'(wr_data[6:5]);
        if (txn_start) st_d.first = 1'b1;
        if (wr_en)     st_d.first = 1'b0;
        if (is_cmd) begin
            st_d.mode = new_mode;
            if (new_mode == XF_SPECIAL) begin
                case (wr_data[ADDR_W-1:0])
                    SF_CLR:   st_d.clr   = 1'b1;
                    SF_STOP:  st_d.stop  = 1'b1;
                    SF_START: st_d.start = 1'b1;
                    default:  ;
                endcase
            end else begin
                st_d.ptr = wr_data[ADDR_W-1:0];
            end
        end else if ((wr_en || rd_en) && st_q.mode == XF_ADVANCE) begin
            st_d.ptr = st_q.ptr + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{ptr: '0, mode: XF_HOLD, first: 1'b1,
                       clr: 1'b0, stop: 1'b0, start: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ptr       = st_q.ptr;
    assign xmode     = st_q.mode;
    assign reg_we    = wr_en & ~is_cmd;
    assign irq_clr   = st_q.clr;
    assign man_stop  = st_q.stop;
    assign man_start = st_q.start;
endmodule

// File: rtl/sensreg_store.sv
module sensreg_store
    import sensreg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   ch0_data,
    input  logic [CH_W-1:0]   ch1_data,
    output logic [1:0]        ctl,
    output logic              valid,
    output logic [BYTE_W-1:0] itime,
    output logic [6:0]        intc,
    output logic [CH_W-1:0]   thl,
    output logic [CH_W-1:0]   thh,
    output logic [1:0]        gain,
    output logic [CH_W-1:0]   d0,
    output logic [CH_W-1:0]   d1,
    output logic [BYTE_W-1:0] sh0,
    output logic [BYTE_W-1:0] sh1
);
    typedef struct packed {
        logic [1:0]        ctl;
        logic              valid;
        logic [BYTE_W-1:0] itime;
        logic [6:0]        intc;
        logic [CH_W-1:0]   thl;
        logic [CH_W-1:0]   thh;
        logic [1:0]        gain;
        logic [CH_W-1:0]   d0;
        logic [CH_W-1:0]   d1;
        logic [BYTE_W-1:0] sh0;
        logic [BYTE_W-1:0] sh1;
    } store_st_t;

    store_st_t rs_d, rs_q;

    always_comb begin
        rs_d = rs_q;
        if (conv_done) begin
            rs_d.d0    = ch0_data;
            rs_d.d1    = ch1_data;
            rs_d.valid = 1'b1;
        end
        if (we) begin
            case (addr)
                A_CTRL: begin
                    rs_d.ctl = wdata[1:0];
                    if (!wdata[1]) rs_d.valid = 1'b0;
                end
                A_TIME:  rs_d.itime            = wdata;
                A_INTC:  rs_d.intc             = wdata[6:0];
                A_TLO_L: rs_d.thl[BYTE_W-1:0]  = wdata;
                A_TLO_H: rs_d.thl[CH_W-1:BYTE_W] = wdata;
                A_THI_L: rs_d.thh[BYTE_W-1:0]  = wdata;
                A_THI_H: rs_d.thh[CH_W-1:BYTE_W] = wdata;
                A_GAIN:  rs_d.gain             = wdata[1:0];
                default: ;
            endcase
        end
        if (rd_en) begin
            if (addr == A_D0_L) rs_d.sh0 = rs_q.d0[CH_W-1:BYTE_W];
            if (addr == A_D1_L) rs_d.sh1 = rs_q.d1[CH_W-1:BYTE_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rs_q <= '0;
        else        rs_q <= rs_d;
    end

    assign ctl   = rs_q.ctl;
    assign valid = rs_q.valid;
    assign itime = rs_q.itime;
    assign intc  = rs_q.intc;
    assign thl   = rs_q.thl;
    assign thh   = rs_q.thh;
    assign gain  = rs_q.gain;
    assign d0    = rs_q.d0;
    assign d1    = rs_q.d1;
    assign sh0   = rs_q.sh0;
    assign sh1   = rs_q.sh1;
endmodule

// File: rtl/sensreg_top.sv
module sensreg_top
    import sensreg_pkg::*;
#(
    parameter logic [3:0]        PART_ID = 4'h9,
    parameter logic [3:0]        REV_ID  = 4'h0,
    parameter logic [BYTE_W-1:0] ID2_VAL = 8'h80
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              txn_start,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   ch0_data,
    input  logic [CH_W-1:0]   ch1_data,
    input  logic              irq_active,
    input  logic [CH_W-1:0]   mtimer,
    output logic              pwr_on,
    output logic              adc_on,
    output logic [BYTE_W-1:0] integ_time,
    output logic [6:0]        irq_ctl,
    output logic [CH_W-1:0]   thr_low,
    output logic [CH_W-1:0]   thr_high,
    output logic [1:0]        gain_sel,
    output logic              irq_clr,
    output logic              man_stop,
    output logic              man_start
);
    logic [ADDR_W-1:0] ptr;
    logic [1:0]        xmode;
    logic              reg_we;
    logic [1:0]        ctl;
    logic              valid;
    logic [1:0]        gain;
    logic [CH_W-1:0]   d0, d1;
    logic [BYTE_W-1:0] sh0, sh1;

    sensreg_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_start (txn_start),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .ptr       (ptr),
        .xmode     (xmode),
        .reg_we    (reg_we),
        .irq_clr   (irq_clr),
        .man_stop  (man_stop),
        .man_start (man_start)
    );

    sensreg_store u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (reg_we),
        .rd_en     (rd_en),
        .addr      (ptr),
        .wdata     (wr_data),
        .conv_done (conv_done),
        .ch0_data  (ch0_data),
        .ch1_data  (ch1_data),
        .ctl       (ctl),
        .valid     (valid),
        .itime     (integ_time),
        .intc      (irq_ctl),
        .thl       (thr_low),
        .thh       (thr_high),
        .gain      (gain),
        .d0        (d0),
        .d1        (d1),
        .sh0       (sh0),
        .sh1       (sh1)
    );

    always_comb begin
        case (ptr)
            A_CTRL:  rd_data = {2'b00, irq_active, valid, 2'b00, ctl};
            A_TIME:  rd_data = integ_time;
            A_INTC:  rd_data = {1'b0, irq_ctl};
            A_TLO_L: rd_data = thr_low[BYTE_W-1:0];
            A_TLO_H: rd_data = thr_low[CH_W-1:BYTE_W];
            A_THI_L: rd_data = thr_high[BYTE_W-1:0];
            A_THI_H: rd_data = thr_high[CH_W-1:BYTE_W];
            A_GAIN:  rd_data = {6'b0, gain};
            A_ID:    rd_data = {PART_ID, REV_ID};
            A_D0_L:  rd_data = d0[BYTE_W-1:0];
            A_D0_H:  rd_data = sh0;
            A_D1_L:  rd_data = d1[BYTE_W-1:0];
            A_D1_H:  rd_data = sh1;
            A_TMR_L: rd_data = mtimer[BYTE_W-1:0];
            A_TMR_H: rd_data = mtimer[CH_W-1:BYTE_W];
            A_ID2:   rd_data = ID2_VAL;
            default: rd_data = '0;
        endcase
    end

    assign pwr_on   = ctl[0];
    assign adc_on   = ctl[1];
    assign gain_sel = gain;
endmodule

// File: rtl/sensreg_chk.sv
module sensreg_chk
    import sensreg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] ptr,
    input logic [1:0]        xmode,
    input logic [BYTE_W-1:0] rd_data,
    input logic              irq_clr,
    input logic              man_stop,
    input logic              man_start
);
    // R5
    pulse_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({irq_clr, man_stop, man_start}));

    // R5
    pulse_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_clr || man_stop || man_start) |-> $past(wr_en));

    // R4
    advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && xmode == 2'b01) |=> (ptr == ADDR_W'($past(ptr) + 1)));

    // R3
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && xmode != 2'b01) |=> $stable(ptr));

    // R8
    id2_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == A_ID2) |-> rd_data[7]);

    // R11
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr == 5'h08 || ptr == 5'h1F) |-> (rd_data == 8'h00));
endmodule

bind sensreg_top sensreg_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .ptr       (ptr),
    .xmode     (xmode),
    .rd_data   (rd_data),
    .irq_clr   (irq_clr),
    .man_stop  (man_stop),
    .man_start (man_start)
);

// File: tb/sim_sensreg_top.sv
module sim_sensreg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        txn_start = 1'b0, wr_en = 1'b0, rd_en = 1'b0, conv_done = 1'b0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [15:0] ch0_data = '0, ch1_data = '0, mtimer = 16'hBEEF;
    logic        irq_active = 1'b0;
    logic        pwr_on, adc_on, irq_clr, man_stop, man_start;
    logic [7:0]  integ_time;
    logic [6:0]  irq_ctl;
    logic [15:0] thr_low, thr_high;
    logic [1:0]  gain_sel;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    // bench register model
    logic [1:0]  m_ctl = '0;
    logic        m_valid = 1'b0;
    logic [7:0]  m_tim = '0;
    logic [6:0]  m_int = '0;
    logic [15:0] m_thl = '0, m_thh = '0, m_d0 = '0, m_d1 = '0;
    logic [1:0]  m_gain = '0;
    logic [7:0]  m_sh0 = '0, m_sh1 = '0;

    always #2.5 clk = ~clk;

    sensreg_top u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic start_txn();
        @(negedge clk); txn_start = 1'b1;
        @(posedge clk); #1 txn_start = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(posedge clk); #1 wr_en = 1'b0;
    endtask

    task automatic rd(output logic [7:0] b);
        @(negedge clk); rd_en = 1'b1; #1 b = rd_data;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic conv(input logic [15:0] a, input logic [15:0] c);
        @(negedge clk); conv_done = 1'b1; ch0_data = a; ch1_data = c;
        @(posedge clk); #1 conv_done = 1'b0;
        m_d0 = a; m_d1 = c; m_valid = 1'b1;
    endtask

    function automatic logic [7:0] model_rd(input logic [4:0] a);
        case (a)
            5'h00: return {2'b00, irq_active, m_valid, 2'b00, m_ctl};
            5'h01: return m_tim;
            5'h02: return {1'b0, m_int};
            5'h03: return m_thl[7:0];
            5'h04: return m_thl[15:8];
            5'h05: return m_thh[7:0];
            5'h06: return m_thh[15:8];
            5'h07: return {6'b0, m_gain};
            5'h12: return 8'h90;
            5'h14: return m_d0[7:0];
            5'h15: return m_sh0;
            5'h16: return m_d1[7:0];
            5'h17: return m_sh1;
            5'h18: return mtimer[7:0];
            5'h19: return mtimer[15:8];
            5'h1E: return 8'h80;
            default: return 8'h00;
        endcase
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        case (a)
            5'h00: return "R6";
            5'h01, 5'h02, 5'h03, 5'h04, 5'h05, 5'h06, 5'h07: return "R7";
            5'h12, 5'h1E: return "R8";
            5'h14, 5'h15, 5'h16, 5'h17: return "R9";
            5'h18, 5'h19: return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model_wr(input logic [4:0] a, input logic [7:0] v);
        case (a)
            5'h00: begin m_ctl = v[1:0]; if (!v[1]) m_valid = 1'b0; end
            5'h01: m_tim = v;
            5'h02: m_int = v[6:0];
            5'h03: m_thl[7:0] = v;
            5'h04: m_thl[15:8] = v;
            5'h05: m_thh[7:0] = v;
            5'h06: m_thh[15:8] = v;
            5'h07: m_gain = v[1:0];
            default: ;
        endcase
    endtask

    initial begin
        #750000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        logic [7:0] b;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        chk("R1 outputs", {pwr_on, adc_on, integ_time, irq_ctl, thr_low, thr_high, gain_sel}, 0);
        chk("R1 pulses", {irq_clr, man_stop, man_start}, 0);
        start_txn(); rd(b); chk("R1 ctrl read", b, 8'h00);

        // R8 identity, write ignored, R3 hold
        start_txn(); wr(8'h92); rd(b); chk("R8 id", b, 8'h90);
        wr(8'h55); rd(b); chk("R8 id write ignored R3", b, 8'h90);
        start_txn(); wr(8'h9E); rd(b); chk("R8 id2", b, 8'h80);

        // R2 later byte with bit 7 set is data
        start_txn(); wr(8'h81); wr(8'hB6); chk("R2 data bit7", integ_time, 8'hB6);
        wr(8'hA5); chk("R3 hold rewrite", integ_time, 8'hA5);

        // R12 pointer kept across transactions
        start_txn(); wr(8'h11); chk("R12 first data byte", integ_time, 8'h11);
        start_txn(); rd(b); chk("R12 pointer kept", b, 8'h11);

        // R7 thresholds via advance, R4
        start_txn(); wr(8'hA3); wr(8'h34); wr(8'h12); wr(8'hCD); wr(8'hAB);
        chk("R7 thr_low", thr_low, 16'h1234);
        chk("R7 thr_high", thr_high, 16'hABCD);
        rd(b); chk("R4 advanced to gain", b, 8'h00);

        // R4 wrap 1Fh -> 00h
        start_txn(); wr(8'hBF); rd(b); chk("R4 at 1Fh R11", b, 8'h00);
        rd(b); chk("R4 wrapped to ctrl", b, 8'h00);

        // sweep write every address, then read back every address
        m_tim = 8'h11; m_thl = 16'h1234; m_thh = 16'hABCD;
        start_txn(); wr(8'hA0);
        for (int a = 0; a < 32; a++) begin
            logic [7:0] v;
            v = 8'((a * 37 + 5) & 8'hFF);
            wr(v);
            model_wr(5'(a), v);
        end
        chk("R7 gain out", gain_sel, m_gain);
        chk("R7 irq_ctl out", irq_ctl, m_int);
        start_txn(); wr(8'hA0);
        for (int a = 0; a < 32; a++) begin
            logic [7:0] e;
            e = model_rd(5'(a));
            rd(b);
            if (a == 5'h14) m_sh0 = m_d0[15:8];
            if (a == 5'h16) m_sh1 = m_d1[15:8];
            chk(tag_of(5'(a)), b, e);
        end

        // R9 held high byte across a new conversion
        conv(16'h1122, 16'h5566);
        start_txn(); wr(8'h94); rd(b); chk("R9 d0 low", b, 8'h22);
        conv(16'h3344, 16'h7788);
        start_txn(); wr(8'h95); rd(b); chk("R9 d0 held high", b, 8'h11);
        start_txn(); wr(8'h96); rd(b); chk("R9 d1 low", b, 8'h88);
        start_txn(); wr(8'h97); rd(b); chk("R9 d1 held high", b, 8'h77);
        start_txn(); wr(8'h94); rd(b); chk("R9 d0 new low", b, 8'h44);

        // R6 control and status
        start_txn(); wr(8'h80); wr(8'h33);
        chk("R6 pwr adc", {pwr_on, adc_on}, 2'b11);
        rd(b); chk("R6 valid set, status bits not written", b, 8'h13);
        irq_active = 1'b1;
        rd(b); chk("R6 irq status", b, 8'h33);
        wr(8'h01); rd(b); chk("R6 valid cleared", b, 8'h21);
        irq_active = 1'b0;

        // R5 special-code sweep
        start_txn(); wr(8'h87); wr(8'h02);
        for (int c = 0; c < 32; c++) begin
            start_txn(); wr(8'(8'hE0 | c));
            chk("R5 pulse", {irq_clr, man_stop, man_start},
                (c == 1) ? 3'b100 : (c == 2) ? 3'b010 : (c == 3) ? 3'b001 : 3'b000);
            @(posedge clk); #1;
            chk("R5 one cycle", {irq_clr, man_stop, man_start}, 0);
        end
        rd(b); chk("R5 pointer unchanged", b, 8'h02);

        // R10 live timer
        mtimer = 16'h1357;
        start_txn(); wr(8'h98); rd(b); chk("R10 timer low", b, 8'h57);
        mtimer = 16'h2468;
        rd(b); chk("R10 timer live", b, 8'h68);
        start_txn(); wr(8'h99); rd(b); chk("R10 timer high", b, 8'h24);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule